// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Port

This block is a watchdog peripheral on an APB slave port with 32-bit registers. A down-counter steps by one on each clock cycle in which the tick-enable input is high. When the count runs out for the first time, the block raises an interrupt flag and starts a new period from the reload value. If the count runs out again while that flag is still pending, the block latches a reset request and stops counting. Software keeps the system alive by clearing the interrupt, which also restarts the period, or by writing a new reload value.

Two enable bits gate the interrupt and reset outputs. Software can read the flag both raw and masked. A key-protected lock shields every other register from stray writes. For board-level testing, a test mode lets software drive both outputs directly from a register.

A parameter selects a second variant. In that variant the control register becomes write-once-enabled: once the interrupt enable is set, later control writes are dropped, so only a reset clears it. The test-mode registers are also absent in that variant.

Two state machines hold the behaviour. The counter machine has three states. In RUN it decrements. In WRAP it sits at zero after a first expiry, and the next tick reloads it. In HALT it is stopped after the second expiry. Its transitions are:
- RUN→WRAP on the 1-to-0 tick with no flag pending.
- RUN→HALT on that tick with the flag pending.
- WRAP→RUN on the next tick, or on a clear or load write.
- HALT→RUN on a load write.
- Any state→RUN on a load write. A clear write moves RUN or WRAP to RUN and leaves HALT in place.

The lock machine has two states, OPEN and SHUT. Writing the key to the lock register moves it to OPEN. Writing any other value moves it to SHUT.

Top module: `twdt_top`

## Requirements
- R1: After reset the control, raw flag, lock, test-mode control, test outputs and reset flag are all zero. Both outputs are low, and the reload and count registers both read 0xFFFFFFFF with the counter running.
- R2: Every APB access completes in one access phase, with pready high and pslverr low. The register offsets are: 0x000 reload, 0x004 count, 0x008 control, 0x00C interrupt clear, 0x010 raw flag, 0x014 masked flag, 0xC00 lock, 0xF00 test control, 0xF04 test outputs.
- R3: A write to 0x000 sets both the reload value and the count to the written data and puts the counter in RUN, even if it was halted.
- R4: In RUN, each tick lowers the count by one. The 1-to-0 tick with no flag pending sets the raw flag (0x010 reads 1). The next tick reloads the count.
- R5: The 1-to-0 tick while the raw flag is pending sets the sticky reset flag and halts the counter. After that, ticks no longer change the count.
- R6: Any write to 0x00C clears the raw flag and copies the reload value into the count, without restarting a halted counter. If such a write lands on the expiry tick, the write wins and no expiry is recorded.
- R7: Control bit 0 enables the interrupt and bit 1 enables the reset. Other control bits read back as zero. wdog_irq and the 0x014 read both equal raw flag AND bit 0. wdog_rst equals reset flag AND bit 1.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the block, and any other value locks it. 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to every offset other than 0xC00 have no effect.
- R9: When bit 0 of 0xF00 is set, bit 0 of 0xF04 drives wdog_rst and bit 1 drives wdog_irq, in place of normal operation. 0xF00 reads back its bit 0.
- R10: With STICKY_CTRL=1, control writes are dropped once control bit 0 is set. Offsets 0xF00 and 0xF04 read zero and writes to them have no effect on the outputs.
- R11: Writes to 0x004, 0x010 and 0x014 change nothing. Reads of the write-only offsets 0x00C and 0xF04, and of unmapped offsets, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high: no wait states |
| pslverr | output | 1 | Always low: no error response |
| tick_en | input | 1 | Counter step enable |
| wdog_irq | output | 1 | Interrupt request |
| wdog_rst | output | 1 | Reset request |

## Verification
Two events can fall in the same cycle: a counter expiry on a tick, and a bus write to the interrupt-clear or reload offset. The bench brings the count to one, then issues the write with tick_en high during its access phase, so both land on one clock edge. It then reads the raw flag and the count. The flag must read zero and the count must hold the reload value (or the newly written value), which shows the write took priority and the expiry was dropped.

// File: rtl/twdt_pkg.sv
package twdt_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        CNT_RUN  = 2'd0,
        CNT_WRAP = 2'd1,
        CNT_HALT = 2'd2
    } cnt_state_t;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_t;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'hC00;
    localparam logic [ADDR_W-1:0] OFS_TCTL   = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_TOUT   = 12'hF04;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

endpackage

// File: rtl/twdt_counter.sv
module twdt_counter
    import twdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             raw_q,
    output logic             rstflag_q
);

    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    cnt_state_t st_q, st_d;
    logic       exp_first, exp_second;

    // next state and expiry events; bus writes take priority over a tick
    always_comb begin
        st_d       = st_q;
        exp_first  = 1'b0;
        exp_second = 1'b0;
        unique case (st_q)
            CNT_RUN: begin
                if (tick && cnt_q == CNT_ONE) begin
                    if (raw_q) begin
                        exp_second = 1'b1;
                        st_d       = CNT_HALT;
                    end else begin
                        exp_first  = 1'b1;
                        st_d       = CNT_WRAP;
                    end
                end
            end
            CNT_WRAP: begin
                if (tick) st_d = CNT_RUN;
            end
            CNT_HALT: begin
                st_d = CNT_HALT;
            end
            default: st_d = CNT_RUN;
        endcase
        if (clr_wr) begin
            exp_first  = 1'b0;
            exp_second = 1'b0;
            if (st_q != CNT_HALT) st_d = CNT_RUN;
        end
        if (load_wr) begin
            exp_first  = 1'b0;
            exp_second = 1'b0;
            st_d       = CNT_RUN;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_RUN;
        else        st_q <= st_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= CNT_MAX;
            reload_q  <= CNT_MAX;
            raw_q     <= 1'b0;
            rstflag_q <= 1'b0;
        end else begin
            if (load_wr) begin
                reload_q <= wdata;
                cnt_q    <= wdata;
            end else if (clr_wr) begin
                raw_q <= 1'b0;
                cnt_q <= reload_q;
            end else begin
                unique case (st_q)
                    CNT_RUN: begin
                        if (tick) begin
                            if (cnt_q == CNT_ZERO) cnt_q <= reload_q;
                            else                   cnt_q <= cnt_q - CNT_ONE;
                        end
                    end
                    CNT_WRAP: begin
                        if (tick) cnt_q <= reload_q;
                    end
                    CNT_HALT: begin
                        cnt_q <= cnt_q;
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end
            if (exp_first)  raw_q     <= 1'b1;
            if (exp_second) rstflag_q <= 1'b1;
        end
    end

    // R4: first expiry raises the raw flag
    a_r4_first_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_RUN && tick && cnt_q == CNT_ONE && !raw_q && !load_wr && !clr_wr)
        |=> (raw_q && cnt_q == CNT_ZERO));

    // R5: second expiry halts and latches the reset flag
    a_r5_second_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_RUN && tick && cnt_q == CNT_ONE && raw_q && !load_wr && !clr_wr)
        |=> (st_q == CNT_HALT && rstflag_q));

    // R5: halted count is frozen
    a_r5_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_HALT && !load_wr && !clr_wr) |=> $stable(cnt_q));

    // R5: reset flag is sticky
    a_r5_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rstflag_q |=> rstflag_q);

    // R3: load restarts from written value
    a_r3_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cnt_q == $past(wdata) && st_q == CNT_RUN));

    // R6: clear drops the raw flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !load_wr) |=> !raw_q);

endmodule

// File: rtl/twdt_regs.sv
module twdt_regs
    import twdt_pkg::*;
#(
    parameter bit STICKY_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic [DATA_W-1:0] reload_val,
    input  logic              raw_flag,
    output logic [DATA_W-1:0] prdata,
    output logic              load_wr,
    output logic              clr_wr,
    output logic [1:0]        ctrl_q,
    output logic              tmode_q,
    output logic [1:0]        tout_q
);

    lock_state_t lk_q, lk_d;
    logic        wr_acc, wr_ok, ctrl_frozen;

    assign wr_acc      = psel && penable && pwrite;
    assign wr_ok       = wr_acc && (lk_q == LK_OPEN || paddr == OFS_LOCK);
    assign load_wr     = wr_ok && paddr == OFS_RELOAD;
    assign clr_wr      = wr_ok && paddr == OFS_ICLR;
    assign ctrl_frozen = STICKY_CTRL && ctrl_q[0];

    // lock machine
    always_comb begin
        lk_d = lk_q;
        if (wr_acc && paddr == OFS_LOCK) begin
            unique case (lk_q)
                LK_OPEN: if (pwdata != UNLOCK_KEY) lk_d = LK_SHUT;
                LK_SHUT: if (pwdata == UNLOCK_KEY) lk_d = LK_OPEN;
                default: lk_d = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_OPEN;
        else        lk_q <= lk_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          ctrl_q <= 2'b00;
        else if (wr_ok && paddr == OFS_CTRL && !ctrl_frozen) ctrl_q <= pwdata[1:0];
    end

    generate
        if (STICKY_CTRL) begin : g_no_test
            assign tmode_q = 1'b0;
            assign tout_q  = 2'b00;
        end else begin : g_test
            logic       tm_r;
            logic [1:0] to_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tm_r <= 1'b0;
                    to_r <= 2'b00;
                end else begin
                    if (wr_ok && paddr == OFS_TCTL) tm_r <= pwdata[0];
                    if (wr_ok && paddr == OFS_TOUT) to_r <= pwdata[1:0];
                end
            end
            assign tmode_q = tm_r;
            assign tout_q  = to_r;
        end
    endgenerate

    // read mux
    always_comb begin
        prdata = '0;
        if (psel) begin
            unique case (paddr)
                OFS_RELOAD: prdata = reload_val;
                OFS_COUNT:  prdata = cnt_val;
                OFS_CTRL:   prdata = {{(DATA_W-2){1'b0}}, ctrl_q};
                OFS_RAW:    prdata = {{(DATA_W-1){1'b0}}, raw_flag};
                OFS_MASKED: prdata = {{(DATA_W-1){1'b0}}, raw_flag & ctrl_q[0]};
                OFS_LOCK:   prdata = {{(DATA_W-1){1'b0}}, (lk_q == LK_SHUT)};
                OFS_TCTL:   prdata = {{(DATA_W-1){1'b0}}, tmode_q};
                default:    prdata = '0;
            endcase
        end
    end

    // R8: locked writes to control do nothing
    a_r8_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_SHUT && wr_acc && paddr == OFS_CTRL) |=> $stable(ctrl_q));

    // R8: key unlocks
    a_r8_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && paddr == OFS_LOCK && pwdata == UNLOCK_KEY) |=> (lk_q == LK_OPEN));

    // R8: a locked block issues no counter commands
    a_r8_no_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_SHUT) |-> !(load_wr || clr_wr));

    generate
        if (STICKY_CTRL) begin : g_sticky_chk
            // R10: interrupt enable cannot be cleared once set
            a_r10_sticky_en: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_q[0] |=> ctrl_q[0]);
        end
    endgenerate

endmodule

// File: rtl/twdt_outsel.sv
module twdt_outsel (
    input  logic       raw_flag,
    input  logic       rst_flag,
    input  logic [1:0] ctrl,
    input  logic       tmode,
    input  logic [1:0] tout,
    output logic       irq,
    output logic       rst
);

    always_comb begin
        if (tmode) begin
            rst = tout[0];
            irq = tout[1];
        end else begin
            irq = raw_flag & ctrl[0];
            rst = rst_flag & ctrl[1];
        end
    end

endmodule

// File: rtl/twdt_top.sv
module twdt_top
    import twdt_pkg::*;
#(
    parameter bit STICKY_CTRL = 1'b0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              wdog_irq,
    output logic              wdog_rst
);

    logic [DATA_W-1:0] cnt_val, reload_val;
    logic              raw_flag, rst_flag, load_wr, clr_wr, tmode;
    logic [1:0]        ctrl, tout;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    twdt_regs #(.STICKY_CTRL(STICKY_CTRL)) u_regs (
        .clk        (pclk),
        .rst_n      (presetn),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .cnt_val    (cnt_val),
        .reload_val (reload_val),
        .raw_flag   (raw_flag),
        .prdata     (prdata),
        .load_wr    (load_wr),
        .clr_wr     (clr_wr),
        .ctrl_q     (ctrl),
        .tmode_q    (tmode),
        .tout_q     (tout)
    );

    twdt_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk       (pclk),
        .rst_n     (presetn),
        .tick      (tick_en),
        .load_wr   (load_wr),
        .clr_wr    (clr_wr),
        .wdata     (pwdata),
        .cnt_q     (cnt_val),
        .reload_q  (reload_val),
        .raw_q     (raw_flag),
        .rstflag_q (rst_flag)
    );

    twdt_outsel u_out (
        .raw_flag (raw_flag),
        .rst_flag (rst_flag),
        .ctrl     (ctrl),
        .tmode    (tmode),
        .tout     (tout),
        .irq      (wdog_irq),
        .rst      (wdog_rst)
    );

    // R9: with test mode off and reset disabled, no reset request leaves the block
    a_r9_rst_gated: assert property (@(posedge pclk) disable iff (!presetn)
        (!tmode && !ctrl[1]) |-> !wdog_rst);

endmodule

// File: tb/twdt_top_test.sv
module twdt_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 63;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_OUT = 2'd3;

    logic        clk = 1'b0, rstn = 1'b0;
    logic        psel_a = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] rd_a, rd_b;
    logic        rdy_a, rdy_b, err_a, err_b, irq_a, irq_b, rst_a, rst_b;
    int          checks = 0, errors = 0, cycles = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    twdt_top #(.STICKY_CTRL(1'b0)) uut (
        .pclk(clk), .presetn(rstn), .psel(psel_a), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd_a), .pready(rdy_a), .pslverr(err_a),
        .tick_en(tick), .wdog_irq(irq_a), .wdog_rst(rst_a));

    twdt_top #(.STICKY_CTRL(1'b1)) uut_alt (
        .pclk(clk), .presetn(rstn), .psel(psel_b), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd_b), .pready(rdy_b), .pslverr(err_b),
        .tick_en(tick), .wdog_irq(irq_b), .wdog_rst(rst_b));

    // vector: op, requirement number, offset, data, expected
    localparam logic [81:0] VEC [NVEC] = '{
        {OP_WR, 4'd7, 12'h008, 32'hFFFF_FFFF, 32'h0},  // R7
        {OP_RD, 4'd7, 12'h008, 32'h0, 32'h3},          // R7
        {OP_WR, 4'd7, 12'h008, 32'h0, 32'h0},
        {OP_WR, 4'd3, 12'h000, 32'h5, 32'h0},          // R3
        {OP_RD, 4'd3, 12'h004, 32'h0, 32'h5},
        {OP_TK, 4'd4, 12'h000, 32'd2, 32'h0},          // R4
        {OP_RD, 4'd4, 12'h004, 32'h0, 32'h3},
        {OP_TK, 4'd4, 12'h000, 32'd2, 32'h0},
        {OP_RD, 4'd4, 12'h004, 32'h0, 32'h1},
        {OP_TK, 4'd4, 12'h000, 32'd1, 32'h0},
        {OP_RD, 4'd4, 12'h004, 32'h0, 32'h0},
        {OP_RD, 4'd4, 12'h010, 32'h0, 32'h1},
        {OP_RD, 4'd7, 12'h014, 32'h0, 32'h0},
        {OP_OUT, 4'd7, 12'h000, 32'h0, 32'h0},
        {OP_WR, 4'd7, 12'h008, 32'h1, 32'h0},
        {OP_RD, 4'd7, 12'h014, 32'h0, 32'h1},
        {OP_OUT, 4'd7, 12'h000, 32'h0, 32'h1},
        {OP_TK, 4'd4, 12'h000, 32'd1, 32'h0},
        {OP_RD, 4'd4, 12'h004, 32'h0, 32'h5},
        {OP_WR, 4'd6, 12'h00C, 32'h0, 32'h0},          // R6
        {OP_RD, 4'd6, 12'h010, 32'h0, 32'h0},
        {OP_OUT, 4'd6, 12'h000, 32'h0, 32'h0},
        {OP_TK, 4'd4, 12'h000, 32'd5, 32'h0},
        {OP_RD, 4'd4, 12'h010, 32'h0, 32'h1},
        {OP_TK, 4'd5, 12'h000, 32'd6, 32'h0},          // R5
        {OP_RD, 4'd5, 12'h004, 32'h0, 32'h0},
        {OP_OUT, 4'd5, 12'h000, 32'h0, 32'h1},
        {OP_WR, 4'd7, 12'h008, 32'h3, 32'h0},
        {OP_OUT, 4'd7, 12'h000, 32'h0, 32'h3},
        {OP_WR, 4'd6, 12'h00C, 32'h0, 32'h0},
        {OP_RD, 4'd6, 12'h004, 32'h0, 32'h5},
        {OP_TK, 4'd5, 12'h000, 32'd2, 32'h0},
        {OP_RD, 4'd5, 12'h004, 32'h0, 32'h5},
        {OP_OUT, 4'd5, 12'h000, 32'h0, 32'h2},
        {OP_WR, 4'd3, 12'h000, 32'h4, 32'h0},
        {OP_TK, 4'd3, 12'h000, 32'd1, 32'h0},
        {OP_RD, 4'd3, 12'h004, 32'h0, 32'h3},
        {OP_OUT, 4'd5, 12'h000, 32'h0, 32'h2},
        {OP_WR, 4'd8, 12'hC00, 32'h1234_5678, 32'h0},  // R8
        {OP_RD, 4'd8, 12'hC00, 32'h0, 32'h1},
        {OP_WR, 4'd8, 12'h000, 32'h9, 32'h0},
        {OP_RD, 4'd8, 12'h000, 32'h0, 32'h4},
        {OP_WR, 4'd8, 12'h008, 32'h0, 32'h0},
        {OP_RD, 4'd8, 12'h008, 32'h0, 32'h3},
        {OP_WR, 4'd8, 12'hC00, 32'h1ACC_E551, 32'h0},
        {OP_RD, 4'd8, 12'hC00, 32'h0, 32'h0},
        {OP_WR, 4'd11, 12'h004, 32'h77, 32'h0},        // R11
        {OP_RD, 4'd11, 12'h004, 32'h0, 32'h3},
        {OP_WR, 4'd11, 12'h010, 32'h1, 32'h0},
        {OP_RD, 4'd11, 12'h010, 32'h0, 32'h0},
        {OP_RD, 4'd11, 12'hF04, 32'h0, 32'h0},
        {OP_RD, 4'd11, 12'h800, 32'h0, 32'h0},
        {OP_WR, 4'd9, 12'hF04, 32'h2, 32'h0},          // R9
        {OP_OUT, 4'd9, 12'h000, 32'h0, 32'h2},
        {OP_WR, 4'd9, 12'hF00, 32'h1, 32'h0},
        {OP_RD, 4'd9, 12'hF00, 32'h0, 32'h1},
        {OP_OUT, 4'd9, 12'h000, 32'h0, 32'h1},
        {OP_WR, 4'd9, 12'hF04, 32'h1, 32'h0},
        {OP_OUT, 4'd9, 12'h000, 32'h0, 32'h2},
        {OP_WR, 4'd9, 12'hF04, 32'h3, 32'h0},
        {OP_OUT, 4'd9, 12'h000, 32'h0, 32'h3},
        {OP_WR, 4'd9, 12'hF00, 32'h0, 32'h0},
        {OP_OUT, 4'd9, 12'h000, 32'h0, 32'h2}
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // one APB transfer; tk raises tick_en on the access-phase edge
    task automatic apb(input bit alt, input bit wr, input logic [11:0] a,
                       input logic [31:0] d, input bit tk, output logic [31:0] r);
        @(negedge clk);
        psel_a = !alt; psel_b = alt; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1; tick = tk;
        r = alt ? rd_b : rd_a;
        @(negedge clk);
        psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired: actual %0d expected below 100000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rstn = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, {30'b0, rst_a, irq_a}, 32'h0, "outputs after reset");
        apb(0, 0, 12'h000, 0, 0, rv); chk(1, rv, 32'hFFFF_FFFF, "reload after reset");
        apb(0, 0, 12'h004, 0, 0, rv); chk(1, rv, 32'hFFFF_FFFF, "count after reset");
        apb(0, 0, 12'h008, 0, 0, rv); chk(1, rv, 32'h0, "control after reset");
        apb(0, 0, 12'hC00, 0, 0, rv); chk(1, rv, 32'h0, "lock after reset");
        apb(0, 0, 12'hF00, 0, 0, rv); chk(1, rv, 32'h0, "test control after reset");
        // R2 handshake
        chk(2, {30'b0, rdy_a, err_a}, 32'h2, "pready/pslverr");

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [11:0] a;
            logic [31:0] d, e;
            {op, rq, a, d, e} = VEC[i];
            unique case (op)
                OP_WR: apb(0, 1, a, d, 0, rv);
                OP_RD: begin apb(0, 0, a, 0, 0, rv); chk(int'(rq), rv, e, $sformatf("vector %0d read 0x%03h", i, a)); end
                OP_TK: ticks(int'(d));
                default: chk(int'(rq), {30'b0, rst_a, irq_a}, e, $sformatf("vector %0d outputs {rst,irq}", i));
            endcase
        end

        // R6 clear on the expiry tick: write wins (count 3, reload 4)
        ticks(2);
        apb(0, 1, 12'h00C, 0, 1, rv);
        apb(0, 0, 12'h010, 0, 0, rv); chk(6, rv, 32'h0, "clear on expiry tick: raw flag");
        apb(0, 0, 12'h004, 0, 0, rv); chk(6, rv, 32'h4, "clear on expiry tick: count");
        // R3 load on the expiry tick
        ticks(3);
        apb(0, 1, 12'h000, 7, 1, rv);
        apb(0, 0, 12'h004, 0, 0, rv); chk(3, rv, 32'h7, "load on expiry tick: count");
        apb(0, 0, 12'h010, 0, 0, rv); chk(3, rv, 32'h0, "load on expiry tick: raw flag");

        // R10 variant
        apb(1, 1, 12'h008, 2, 0, rv);
        apb(1, 0, 12'h008, 0, 0, rv); chk(10, rv, 32'h2, "variant control before enable");
        apb(1, 1, 12'h008, 1, 0, rv);
        apb(1, 1, 12'h008, 0, 0, rv);
        apb(1, 0, 12'h008, 0, 0, rv); chk(10, rv, 32'h1, "variant control sticky");
        apb(1, 1, 12'hF04, 3, 0, rv);
        apb(1, 1, 12'hF00, 1, 0, rv);
        apb(1, 0, 12'hF00, 0, 0, rv); chk(10, rv, 32'h0, "variant test control absent");
        chk(10, {30'b0, rst_b, irq_b}, 32'h0, "variant outputs ignore test writes");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule